// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Drive Controller

This block turns a single PWM command into two gate drive requests for a synchronous buck power stage: one for the high-side switch and one for the low-side synchronous rectifier. Dead time is not a fixed count. The block reads two digitized gate-state bits from external comparators. One bit says the high-side gate is still above threshold with respect to the switch node. The other says the low-side gate is still above threshold with respect to ground. A drive request is raised only once the opposite switch reads as off, so the gap between the two conduction intervals matches the real turn-off time of the switch. A short gap keeps the rectifier's body diode out of conduction for as little time as possible.

Both feedback bits pass through a synchronizer before they are used. After reset, the synchronizer treats each gate as still on. If a feedback bit never confirms turn-off, a cycle counter forces the pending transition after a parameterized number of cycles. A low enable or a high fault input holds both drives off. If PWM reverses while a transition is still waiting, the controller turns toward the new direction at once. Neither drive pulses on during that change.

Top module: `gate_nonoverlap_ctrl`

## Requirements
- R1: While rst_n is low, both hi_drv_o and lo_drv_o are 0.
- R2: hi_drv_o and lo_drv_o are never 1 in the same cycle.
- R3: When en_i is 0 or fault_i is 1 at a rising edge, both drives are 0 after that edge.
- R4: hi_drv_o rises only when PWM was 1 and lo_drv_o was 0 in the previous cycle. With pwm_i=1 and lo_gate_fb_i=0 held, hi_drv_o goes to 1.
- R5: lo_drv_o rises only when PWM was 0 and hi_drv_o was 0 in the previous cycle. With pwm_i=0 and hi_gate_fb_i=0 held, lo_drv_o goes to 1.
- R6: While the feedback bit of the opposite switch reads 1 (gate still on), and the timeout has not expired, both drives stay 0.
- R7: A pending transition is forced after TIMEOUT_CYC cycles in the waiting state. With the default of 8, the drive rises on the 9th rising edge after PWM changes, counted from the edge that turns the old drive off.
- R8: A feedback bit passes through SYNC_STAGES (2) flops. With the default of 2, a feedback fall releases the waiting drive on the 3rd rising edge after the change, not earlier.
- R9: A PWM reversal during a wait redirects the controller with no pulse on the other drive. Every switch from one drive to the other passes through at least one cycle with both drives at 0.
- R10: Starting from the disabled state, raising en_i begins with the drive that pwm_i selects. pwm_i=1 selects the high side and pwm_i=0 selects the low side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable. 0 forces both drives off |
| fault_i | input | 1 | Fault. 1 forces both drives off |
| pwm_i | input | 1 | PWM command. 1 means high side on, 0 means low side on |
| hi_gate_fb_i | input | 1 | 1 while the high-side gate is above threshold with respect to the switch node |
| lo_gate_fb_i | input | 1 | 1 while the low-side gate is above threshold with respect to ground |
| hi_drv_o | output | 1 | High-side drive request |
| lo_drv_o | output | 1 | Low-side drive request |

## Verification
A wrong internal state shows up at the drive pins within one cycle of the edge where it is taken. A wrong next-state choice raises a drive that should stay off, which breaks the overlap and prior-off checks on that same edge. It can also hold both drives low past the expected release cycle. A wrong timeout count or synchronizer depth moves the release edge, so the bench samples exactly one cycle before and one cycle after the expected edge. A lost redirection leaves the old drive low or briefly raises the other drive, and the bench checks that drive every cycle.

// File: rtl/nonov_pkg.sv
`timescale 1ns/1ps
package nonov_pkg;
   typedef enum logic [2:0] {
      ST_OFF     = 3'd0,
      ST_WAIT_LO = 3'd1,   // heading for high side, waiting for low gate off
      ST_HI      = 3'd2,
      ST_WAIT_HI = 3'd3,   // heading for low side, waiting for high gate off
      ST_LO      = 3'd4
   } drv_state_e;
endpackage

// File: rtl/nonov_sync.sv
`timescale 1ns/1ps
module nonov_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("nonov_sync: STAGES must be at least 2");
      end
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain_q;
         // reset to 1: a gate is assumed on until proven off
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
         end
         assign q_o[b] = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nonov_timer.sv
`timescale 1ns/1ps
module nonov_timer #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic restart_i,
   output logic expire_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   assign expire_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (restart_i || !run_i) cnt_q <= '0;
      else if (!expire_o)          cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/nonov_fsm.sv
`timescale 1ns/1ps
module nonov_fsm
   import nonov_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic fault_i,
   input  logic pwm_i,
   input  logic hi_on_i,
   input  logic lo_on_i,
   input  logic expire_i,
   output logic waiting_o,
   output logic restart_o,
   output logic hi_drv_o,
   output logic lo_drv_o
);
   drv_state_e st_q, st_nx;

   always_comb begin
      st_nx = st_q;
      if (!en_i || fault_i) begin
         st_nx = ST_OFF;
      end else begin
         unique case (st_q)
            ST_OFF:     st_nx = pwm_i ? ST_WAIT_LO : ST_WAIT_HI;
            ST_WAIT_LO: if (!pwm_i)                     st_nx = ST_WAIT_HI;
                        else if (!lo_on_i || expire_i) st_nx = ST_HI;
            ST_HI:      if (!pwm_i)                     st_nx = ST_WAIT_HI;
            ST_WAIT_HI: if (pwm_i)                      st_nx = ST_WAIT_LO;
                        else if (!hi_on_i || expire_i) st_nx = ST_LO;
            ST_LO:      if (pwm_i)                      st_nx = ST_WAIT_LO;
            default:    st_nx = ST_OFF;
         endcase
      end
   end

   assign waiting_o = (st_q == ST_WAIT_LO) || (st_q == ST_WAIT_HI);
   assign restart_o = (st_nx != st_q);

   // drive outputs are flops of their own: no decode glitches at the pins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_OFF;
         hi_drv_o <= 1'b0;
         lo_drv_o <= 1'b0;
      end else begin
         st_q     <= st_nx;
         hi_drv_o <= (st_nx == ST_HI);
         lo_drv_o <= (st_nx == ST_LO);
      end
   end
endmodule

// File: rtl/gate_nonoverlap_ctrl.sv
`timescale 1ns/1ps
module gate_nonoverlap_ctrl #(
   parameter int TIMEOUT_CYC = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic fault_i,
   input  logic pwm_i,
   input  logic hi_gate_fb_i,
   input  logic lo_gate_fb_i,
   output logic hi_drv_o,
   output logic lo_drv_o
);
   localparam int FB_W = 2;

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_tmo
         $error("gate_nonoverlap_ctrl: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic [FB_W-1:0] fb_sync;
   logic            waiting, restart, expire;

   nonov_sync #(.STAGES(SYNC_STAGES), .WIDTH(FB_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({hi_gate_fb_i, lo_gate_fb_i}),
      .q_o   (fb_sync)
   );

   nonov_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (waiting),
      .restart_i (restart),
      .expire_o  (expire)
   );

   nonov_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_i),
      .fault_i   (fault_i),
      .pwm_i     (pwm_i),
      .hi_on_i   (fb_sync[1]),
      .lo_on_i   (fb_sync[0]),
      .expire_i  (expire),
      .waiting_o (waiting),
      .restart_o (restart),
      .hi_drv_o  (hi_drv_o),
      .lo_drv_o  (lo_drv_o)
   );
endmodule

// File: rtl/nonov_chk.sv
`timescale 1ns/1ps
module nonov_chk (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic fault_i,
   input logic pwm_i,
   input logic hi_drv_o,
   input logic lo_drv_o
);
   // R2
   overlap_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_drv_o && lo_drv_o));

   // R3
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i || fault_i) |=> (!hi_drv_o && !lo_drv_o));

   // R4
   hi_after_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_drv_o) |-> ($past(pwm_i) && !$past(lo_drv_o)));

   // R5
   lo_after_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_drv_o) |-> (!$past(pwm_i) && !$past(hi_drv_o)));

   // R9
   lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_drv_o |=> !hi_drv_o);

   // R9
   hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_drv_o |=> !lo_drv_o);
endmodule

bind gate_nonoverlap_ctrl nonov_chk u_nonov_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_i     (en_i),
   .fault_i  (fault_i),
   .pwm_i    (pwm_i),
   .hi_drv_o (hi_drv_o),
   .lo_drv_o (lo_drv_o)
);

// File: tb/tb_gate_nonoverlap_ctrl.sv
`timescale 1ns/1ps
module tb_gate_nonoverlap_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 1'b0, fault_i = 1'b0, pwm_i = 1'b0;
   logic hi_gate_fb_i = 1'b0, lo_gate_fb_i = 1'b0;
   logic hi_drv_o, lo_drv_o;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   gate_nonoverlap_ctrl #(.TIMEOUT_CYC(8), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .fault_i(fault_i), .pwm_i(pwm_i),
      .hi_gate_fb_i(hi_gate_fb_i), .lo_gate_fb_i(lo_gate_fb_i),
      .hi_drv_o(hi_drv_o), .lo_drv_o(lo_drv_o));

   // [13]en [12]fault [11]pwm [10]hi_fb [9]lo_fb [8:2]cycles [1]exp_hi [0]exp_lo
   localparam int NV = 10;
   localparam logic [13:0] VEC [NV] = '{
      {1'b0,1'b0,1'b1,1'b0,1'b0,7'd4, 1'b0,1'b0},   // R3 disabled
      {1'b1,1'b0,1'b1,1'b1,1'b0,7'd5, 1'b1,1'b0},   // R10 R4 start high
      {1'b1,1'b0,1'b0,1'b1,1'b0,7'd5, 1'b0,1'b0},   // R6 high gate still on
      {1'b1,1'b0,1'b0,1'b0,1'b1,7'd4, 1'b0,1'b1},   // R5 low released
      {1'b1,1'b0,1'b1,1'b0,1'b1,7'd5, 1'b0,1'b0},   // R6 low gate still on
      {1'b1,1'b0,1'b1,1'b0,1'b0,7'd4, 1'b1,1'b0},   // R4 high released
      {1'b1,1'b0,1'b1,1'b1,1'b0,7'd3, 1'b1,1'b0},   // R4 high held
      {1'b1,1'b0,1'b0,1'b1,1'b0,7'd12,1'b0,1'b1},   // R7 forced by timeout
      {1'b1,1'b1,1'b0,1'b1,1'b0,7'd2, 1'b0,1'b0},   // R3 fault
      {1'b1,1'b0,1'b0,1'b1,1'b0,7'd3, 1'b0,1'b0}    // R6 restart, waits
   };

   task automatic check(input string req, input logic got_hi, input logic got_lo,
                        input logic exp_hi, input logic exp_lo);
      n_chk++;
      if (got_hi !== exp_hi || got_lo !== exp_lo) begin
         n_bad++;
         $display("FAIL %s: hi/lo actual %b%b expected %b%b at %0t",
                  req, got_hi, got_lo, exp_hi, exp_lo, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic en, input logic flt, input logic pwm,
                        input logic hfb, input logic lfb);
      en_i = en; fault_i = flt; pwm_i = pwm; hi_gate_fb_i = hfb; lo_gate_fb_i = lfb;
   endtask

   initial begin
      // R1: reset holds both off even with an active command
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      edges(4);
      check("R1", hi_drv_o, lo_drv_o, 1'b0, 1'b0);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      edges(2);
      check("R1", hi_drv_o, lo_drv_o, 1'b0, 1'b0);
      rst_n = 1'b1;
      edges(2);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9]);
         edges(int'(VEC[i][8:2]));
         check($sformatf("R3/R4/R5/R6/R7 vec%0d", i), hi_drv_o, lo_drv_o,
               VEC[i][1], VEC[i][0]);
      end

      // R7: exact timeout edge
      drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      edges(6);
      check("R7 setup", hi_drv_o, lo_drv_o, 1'b1, 1'b0);
      drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      edges(8);
      check("R7 before", hi_drv_o, lo_drv_o, 1'b0, 1'b0);
      edges(1);
      check("R7 at", hi_drv_o, lo_drv_o, 1'b0, 1'b1);

      // R8: synchronizer latency on a feedback fall
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      edges(3);
      check("R8 setup", hi_drv_o, lo_drv_o, 1'b0, 1'b1);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      edges(3);
      check("R8 wait", hi_drv_o, lo_drv_o, 1'b0, 1'b0);
      drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      edges(2);
      check("R8 edge2", hi_drv_o, lo_drv_o, 1'b0, 1'b0);
      edges(1);
      check("R8 edge3", hi_drv_o, lo_drv_o, 1'b1, 1'b0);

      // R9: reversal during a wait
      drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      edges(3);
      check("R9 setup", hi_drv_o, lo_drv_o, 1'b1, 1'b0);
      drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      edges(1);
      check("R9 e1", hi_drv_o, lo_drv_o, 1'b0, 1'b0);
      edges(1);
      check("R9 e2", hi_drv_o, lo_drv_o, 1'b0, 1'b0);
      drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      edges(1);
      check("R9 e3", hi_drv_o, lo_drv_o, 1'b0, 1'b0);
      edges(1);
      check("R9 e4", hi_drv_o, lo_drv_o, 1'b1, 1'b0);

      // R3: enable drop takes effect on the next edge
      drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      edges(1);
      check("R3 en drop", hi_drv_o, lo_drv_o, 1'b0, 1'b0);

      // R10: enable with pwm low starts on the low side
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      edges(3);
      check("R10 low start", hi_drv_o, lo_drv_o, 1'b0, 1'b1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule